// File: doc/BRIEF.md
# Low-Voltage Inhibit Reset Controller

This block supervises the supply. It receives the supply voltage as a digital code, passes it through a synchronizer, and compares it against a falling trip threshold and a higher rising trip threshold. A range-select input picks one of two parameterized threshold pairs. A trip is accepted only after two consecutive low samples. Once accepted, the low-voltage condition holds until the supply has climbed above the rising threshold for two consecutive samples. This hysteresis stops the device from chattering in and out of reset near the trip level.

The low-voltage condition appears in two places. Software reads it as bit 7 of a byte-wide status register at one parameterized address. It also drives a reset request, mirrored on an active-low external reset pin. Configuration inputs control the monitor. One powers it down. One suppresses reset generation so that the flag can only be polled. One keeps the monitor running while the device is in stop mode.

The controller is a five-state machine:
- ST_OFF: the monitor is disabled.
- ST_NORMAL: the supply is good.
- ST_LOW_PEND: one low sample has been seen.
- ST_TRIPPED: the low condition is confirmed.
- ST_RECOV_PEND: one sample above the rising threshold has been seen while tripped.

The transitions are:
- Any state goes to ST_OFF when the monitor is inactive.
- ST_OFF goes to ST_NORMAL when the monitor is active.
- ST_NORMAL goes to ST_LOW_PEND on a low sample.
- ST_LOW_PEND goes to ST_TRIPPED on a second low sample, or back to ST_NORMAL otherwise.
- ST_TRIPPED goes to ST_RECOV_PEND on a high sample.
- ST_RECOV_PEND goes to ST_NORMAL on a second high sample, or back to ST_TRIPPED otherwise.

Top module: `lvi_monitor`

## Requirements
- R1: During and after reset the status register reads 0x00, `lvi_reset` is 0 and `ext_rst_n` is 1.
- R2: With the monitor active and `cfg_rst_dis`=0, a supply code at or below the falling threshold sets the flag and asserts `lvi_reset`.
- R3: Once tripped, the flag and the reset stay asserted until the code is strictly above the rising threshold. The rising threshold exceeds the falling threshold.
- R4: A low condition must be seen on two consecutive synchronized samples. A code change applied just before clock edge k affects the flag after edge k+3, and a single-sample low is rejected.
- R5: With `cfg_rst_dis`=1, `lvi_reset` is 0 while the flag still tracks the supply. The effect is combinational on the reset output.
- R6: With `cfg_pwrdn`=1 the monitor is off. On the next clock the flag and the reset are cleared, and they stay 0.
- R7: With `stop_mode`=1 and `cfg_stop_en`=0 the monitor is gated off, as in R6. With `cfg_stop_en`=1 it keeps running in stop mode.
- R8: `cfg_range_lo`=0 selects the pair (FALL_HI, RISE_HI). `cfg_range_lo`=1 selects the pair (FALL_LO, RISE_LO).
- R9: With `rd_en`=1 and `rd_addr`=STATUS_ADDR, `rd_data` bit 7 is the flag and bits 6..0 are 0. Any other address, or `rd_en`=0, gives 0x00. The register has no write path.
- R10: `ext_rst_n` is always the inverse of `lvi_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_code | input | VW | Digitized supply voltage |
| cfg_pwrdn | input | 1 | 1 powers the monitor down |
| cfg_rst_dis | input | 1 | 1 suppresses reset generation (polling only) |
| cfg_stop_en | input | 1 | 1 keeps the monitor active in stop mode |
| cfg_range_lo | input | 1 | Threshold pair select (1 = low-supply pair) |
| stop_mode | input | 1 | Device is in stop mode |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data |
| lvi_reset | output | 1 | Active-high reset request |
| ext_rst_n | output | 1 | Active-low external reset pin drive |

## Verification
The assertions check four properties on every cycle:
- the reset pin is always the inverse of the request;
- reset disable suppresses the request;
- power-down and ungated stop clear the request by the following cycle;
- the unimplemented status bits always read zero.

The threshold behaviour can only be shown by the bench's scenarios. The bench sweeps every supply code down and then up, in both ranges and with reset enabled and disabled. These sweeps cover the hysteresis band, the exact trip edges and the range selection. The bench also covers the exact trip latency, rejection of single-sample glitches, re-arming after the monitor is disabled, and address decode.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_NORMAL,
        ST_LOW_PEND,
        ST_TRIPPED,
        ST_RECOV_PEND
    } lvi_state_e;
endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/lvi_thresh.sv
module lvi_thresh #(
    parameter int         W       = 8,
    parameter logic [W-1:0] FALL_HI = 170,
    parameter logic [W-1:0] RISE_HI = 180,
    parameter logic [W-1:0] FALL_LO = 100,
    parameter logic [W-1:0] RISE_LO = 110
) (
    input  logic         range_lo,
    input  logic [W-1:0] code,
    output logic         low_now,
    output logic         high_now
);
    logic [W-1:0] fall_thr, rise_thr;

    always_comb begin
        fall_thr = range_lo ? FALL_LO : FALL_HI;
        rise_thr = range_lo ? RISE_LO : RISE_HI;
        low_now  = (code <= fall_thr);
        high_now = (code >  rise_thr);
    end
endmodule

// File: rtl/lvi_fsm.sv
module lvi_fsm
    import lvi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic low_now,
    input  logic high_now,
    output logic tripped
);
    lvi_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!active) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:        state_nx = ST_NORMAL;
                ST_NORMAL:     state_nx = low_now  ? ST_LOW_PEND   : ST_NORMAL;
                ST_LOW_PEND:   state_nx = low_now  ? ST_TRIPPED    : ST_NORMAL;
                ST_TRIPPED:    state_nx = high_now ? ST_RECOV_PEND : ST_TRIPPED;
                ST_RECOV_PEND: state_nx = high_now ? ST_NORMAL     : ST_TRIPPED;
                default:       state_nx = ST_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_TRIPPED, ST_RECOV_PEND: tripped = 1'b1;
            default:                   tripped = 1'b0;
        endcase
    end
endmodule

// File: rtl/lvi_status_port.sv
module lvi_status_port #(
    parameter int           AW   = 8,
    parameter logic [AW-1:0] ADDR = 8'h3C
) (
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          flag,
    output logic [7:0]    rd_data
);
    always_comb begin
        rd_data = 8'h00;
        if (rd_en && rd_addr == ADDR) rd_data = {flag, 7'b0};
    end
endmodule

// File: rtl/lvi_monitor.sv
module lvi_monitor #(
    parameter int            VW          = 8,
    parameter int            AW          = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] STATUS_ADDR = 8'h3C,
    parameter logic [VW-1:0] FALL_HI     = 170,
    parameter logic [VW-1:0] RISE_HI     = 180,
    parameter logic [VW-1:0] FALL_LO     = 100,
    parameter logic [VW-1:0] RISE_LO     = 110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vdd_code,
    input  logic          cfg_pwrdn,
    input  logic          cfg_rst_dis,
    input  logic          cfg_stop_en,
    input  logic          cfg_range_lo,
    input  logic          stop_mode,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          lvi_reset,
    output logic          ext_rst_n
);
    logic [VW-1:0] code_s;
    logic          low_now, high_now, tripped, active;

    assign active = !cfg_pwrdn && (!stop_mode || cfg_stop_en);

    lvi_sync #(.W(VW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(vdd_code), .dout(code_s)
    );

    lvi_thresh #(.W(VW), .FALL_HI(FALL_HI), .RISE_HI(RISE_HI),
                 .FALL_LO(FALL_LO), .RISE_LO(RISE_LO)) u_thr (
        .range_lo(cfg_range_lo), .code(code_s),
        .low_now(low_now), .high_now(high_now)
    );

    lvi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active),
        .low_now(low_now), .high_now(high_now), .tripped(tripped)
    );

    lvi_status_port #(.AW(AW), .ADDR(STATUS_ADDR)) u_stat (
        .rd_en(rd_en), .rd_addr(rd_addr), .flag(tripped), .rd_data(rd_data)
    );

    assign lvi_reset = tripped && !cfg_rst_dis;
    assign ext_rst_n = !lvi_reset;
endmodule

// File: rtl/lvi_monitor_chk.sv
module lvi_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_pwrdn,
    input logic       cfg_rst_dis,
    input logic       cfg_stop_en,
    input logic       stop_mode,
    input logic [7:0] rd_data,
    input logic       lvi_reset,
    input logic       ext_rst_n
);
    assert_pin_inverse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_n == !lvi_reset);

    assert_rst_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_dis |-> !lvi_reset);

    assert_pwrdn_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pwrdn |=> !lvi_reset);

    assert_stop_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !cfg_stop_en) |=> !lvi_reset);

    assert_low_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:0] == 7'b0);
endmodule

bind lvi_monitor lvi_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_pwrdn(cfg_pwrdn), .cfg_rst_dis(cfg_rst_dis),
    .cfg_stop_en(cfg_stop_en), .stop_mode(stop_mode), .rd_data(rd_data),
    .lvi_reset(lvi_reset), .ext_rst_n(ext_rst_n)
);

// File: tb/lvi_monitor_test.sv
`timescale 1ns/1ps
module lvi_monitor_test;
    localparam int         VW   = 8;
    localparam int         AW   = 8;
    localparam logic [7:0] ADDR = 8'h3C;
    localparam int FHI = 170, RHI = 180, FLO = 100, RLO = 110;

    logic clk = 0, rst_n = 0;
    logic [VW-1:0] vdd_code = 8'hFF;
    logic cfg_pwrdn = 0, cfg_rst_dis = 0, cfg_stop_en = 0, cfg_range_lo = 0, stop_mode = 0;
    logic rd_en = 1;
    logic [AW-1:0] rd_addr = ADDR;
    logic [7:0] rd_data;
    logic lvi_reset, ext_rst_n;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lvi_monitor #(.VW(VW), .AW(AW), .STATUS_ADDR(ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .vdd_code(vdd_code), .cfg_pwrdn(cfg_pwrdn),
        .cfg_rst_dis(cfg_rst_dis), .cfg_stop_en(cfg_stop_en), .cfg_range_lo(cfg_range_lo),
        .stop_mode(stop_mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .lvi_reset(lvi_reset), .ext_rst_n(ext_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input bit f, input string rf, input string rr);
        bit r;
        r = f && !cfg_rst_dis;
        chk(rd_data == (f ? 8'h80 : 8'h00), rf, rd_data, f ? 128 : 0);
        chk(lvi_reset == r, rr, lvi_reset, r);
        chk(ext_rst_n == !lvi_reset, "R10", ext_rst_n, !lvi_reset);
    endtask

    task automatic sweep(input bit rng, input bit dis);
        int fall, rise;
        bit ef;
        string rf;
        fall = rng ? FLO : FHI;
        rise = rng ? RLO : RHI;
        cfg_range_lo = rng;
        cfg_rst_dis  = dis;
        ef = 0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 256; k++) begin
                int c;
                c = (pass == 0) ? 255 - k : k;
                vdd_code = c[7:0];
                if (!ef && c <= fall) ef = 1;
                else if (ef && c > rise) ef = 0;
                wait_n(5);
                rf = (c > fall && c <= rise) ? "R3" : (rng ? "R8" : "R2");
                check_state(ef, rf, dis ? "R5" : "R2");
            end
        end
    endtask

    initial begin
        // R1: reset state
        wait_n(3);
        check_state(0, "R1", "R1");
        rst_n = 1;
        wait_n(6);
        check_state(0, "R1", "R1");

        // R2 R3 R8 R5 sweeps
        sweep(0, 0);
        sweep(1, 0);
        sweep(0, 1);
        sweep(1, 1);
        cfg_range_lo = 0; cfg_rst_dis = 0;
        vdd_code = 8'hFF;
        wait_n(6);

        // R4: single-sample glitch rejected
        vdd_code = 8'h00; wait_n(1);
        vdd_code = 8'hFF; wait_n(6);
        check_state(0, "R4", "R4");
        // R4: latency
        vdd_code = 8'h00; wait_n(3);
        check_state(0, "R4", "R4");
        wait_n(1);
        check_state(1, "R4", "R4");

        // R5: disable is immediate on the reset output, flag kept
        cfg_rst_dis = 1; wait_n(1);
        check_state(1, "R5", "R5");
        cfg_rst_dis = 0; wait_n(1);
        check_state(1, "R5", "R5");

        // R6: power-down clears on next clock and stays clear
        cfg_pwrdn = 1; wait_n(1);
        check_state(0, "R6", "R6");
        wait_n(5);
        check_state(0, "R6", "R6");
        cfg_pwrdn = 0; wait_n(2);
        check_state(0, "R6", "R6");
        wait_n(2);
        check_state(1, "R6", "R6");

        // R7: stop gating
        stop_mode = 1; cfg_stop_en = 0; wait_n(1);
        check_state(0, "R7", "R7");
        wait_n(4);
        check_state(0, "R7", "R7");
        cfg_stop_en = 1; wait_n(5);
        check_state(1, "R7", "R7");
        stop_mode = 0; cfg_stop_en = 0; wait_n(2);
        check_state(1, "R7", "R7");

        // R9: address decode
        rd_addr = ADDR + 8'd1; #0.1;
        chk(rd_data == 8'h00, "R9", rd_data, 0);
        rd_addr = ADDR; rd_en = 0; #0.1;
        chk(rd_data == 8'h00, "R9", rd_data, 0);
        rd_en = 1; #0.1;
        chk(rd_data == 8'h80, "R9", rd_data, 128);

        // R3: recovery in the hysteresis band holds, above releases
        vdd_code = 8'(RHI); wait_n(6);
        check_state(1, "R3", "R3");
        vdd_code = 8'(RHI + 1); wait_n(6);
        check_state(0, "R3", "R3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule